// File: doc/BRIEF.md
# Masked Scan-Out Compactor with Chain Selection

This block merges the outputs of several internal scan chains onto a single external scan-out channel. Each chain bit is gated by its own AND mask, and the masked bits are folded together by a balanced XOR tree. A register sits between the tree and the channel pin, so the long combinational path ends at a flop and the pin is driven straight from a register.

A small serial mask register sets which chains are observed. It holds a single-chain enable and a chain index. With the enable clear, every chain reaches the XOR tree. With it set, a decoder passes only the indexed chain and forces the others to zero. A channel mismatch can then be traced to one chain. A separate bypass input skips masking and compaction altogether and routes the indexed chain straight into the output register. All three modes share that register, so the channel latency is always one clock.

Top module: `scan_compactor_top`

## Requirements
- R1: In compacted mode (bypass low, single-chain enable clear), on a rising edge with shift_en high the output register captures the XOR of all chain bits. `scan_out` shows that value from this edge until the next capturing edge.
- R2: After reset the mask register is all zeros, so the single-chain enable is clear and every chain is observed in the XOR.
- R3: With the single-chain enable set and bypass low, `scan_out` equals the bit of chain `index` captured at the previous shift edge. The other chains have no effect on it.
- R4: With `bypass_en` high, the output register captures bit `index` of `chain_in` without masking or XOR, whatever the state of the single-chain enable. The latency is the same one cycle.
- R5: The mask register is SEL_W+1 bits wide. Bit SEL_W is the single-chain enable and bits SEL_W-1:0 are the chain index. On each edge where it loads, `mask_in` enters at the top bit and the contents shift one place toward bit 0. The first bit shifted in therefore ends in bit 0 after SEL_W+1 loads.
- R6: While `shift_en` is high the mask register holds its value and `mask_load` is ignored.
- R7: While `shift_en` is low the output register holds its value, whatever the chain inputs do.
- R8: A synchronous active-high reset clears the output register to 0 and the mask register to all zeros on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Scan shift enable; the output register captures only while high |
| chain_in | input | NUM_CHAINS | Current output bit of each internal chain |
| bypass_en | input | 1 | Route chain `index` directly, skipping masking and XOR |
| mask_load | input | 1 | Shift `mask_in` into the mask register (only while shift_en is low) |
| mask_in | input | 1 | Serial mask data |
| scan_out | output | 1 | External channel bit, driven from the output register |

## Verification
The properties assume that `rst` is held for at least one edge before any check starts. They also assume `chain_in`, `shift_en`, `bypass_en` and the mask controls change only away from the rising edge, so each edge captures one stable value. The bench drives every input on the falling edge and samples on the following falling edge. With the default four chains the index always names an existing chain, so the single-chain property never meets an out-of-range index. Mask loads are issued with `shift_en` low, except in the one scenario that deliberately overlaps them to show the load is ignored.

// File: rtl/scan_compactor_pkg.sv
package scan_compactor_pkg;

    typedef enum logic [1:0] {
        OBS_ALL    = 2'd0,
        OBS_SINGLE = 2'd1,
        OBS_BYPASS = 2'd2
    } obs_mode_e;

    function automatic obs_mode_e pick_mode(input logic bypass, input logic single);
        if (bypass)      return OBS_BYPASS;
        else if (single) return OBS_SINGLE;
        else             return OBS_ALL;
    endfunction

endpackage

// File: rtl/scan_mask_reg.sv
module scan_mask_reg #(
    parameter int MASK_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              load,
    input  logic              ser_in,
    output logic [MASK_W-1:0] mask_o
);
    typedef struct packed {
        logic [MASK_W-1:0] bits;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.bits = '0;
        end else if (load && !shift_en) begin
            st_d.bits = {ser_in, st_q.bits[MASK_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mask_o = st_q.bits;

    // R6: no change while shifting scan data
    a_r6_hold_in_shift: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> $stable(mask_o));

    // R5: serial entry at the top bit
    a_r5_serial_entry: assert property (@(posedge clk) disable iff (rst)
        (load && !shift_en) |=> (mask_o[MASK_W-1] == $past(ser_in)));

    // R8: reset clears the mask
    a_r8_mask_reset: assert property (@(posedge clk)
        rst |=> (mask_o == '0));
endmodule

// File: rtl/scan_chain_decoder.sv
module scan_chain_decoder #(
    parameter int NUM_CHAINS = 4,
    parameter int SEL_W      = 2
) (
    input  logic                  single_en,
    input  logic [SEL_W-1:0]      index,
    output logic [NUM_CHAINS-1:0] enable
);
    logic [NUM_CHAINS-1:0] onehot;

    for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_dec
        assign onehot[g] = (index == SEL_W'(g));
    end

    always_comb begin
        if (single_en) enable = onehot;
        else           enable = '1;
    end
endmodule

// File: rtl/scan_xor_compactor.sv
module scan_xor_compactor #(
    parameter int NUM_CHAINS = 4
) (
    input  logic [NUM_CHAINS-1:0] chain_in,
    input  logic [NUM_CHAINS-1:0] enable,
    output logic                  folded
);
    localparam int LEVELS = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1;
    localparam int LEAVES = 1 << LEVELS;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [NODES-1:0] node;

    for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
        if (g < NUM_CHAINS) begin : g_real
            assign node[LEAVES-1+g] = chain_in[g] & enable[g];
        end else begin : g_pad
            assign node[LEAVES-1+g] = 1'b0;
        end
    end

    for (genvar i = 0; i < LEAVES - 1; i++) begin : g_tree
        assign node[i] = node[2*i+1] ^ node[2*i+2];
    end

    assign folded = node[0];
endmodule

// File: rtl/scan_compactor_top.sv
module scan_compactor_top
    import scan_compactor_pkg::*;
#(
    parameter int NUM_CHAINS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  shift_en,
    input  logic [NUM_CHAINS-1:0] chain_in,
    input  logic                  bypass_en,
    input  logic                  mask_load,
    input  logic                  mask_in,
    output logic                  scan_out
);
    localparam int SEL_W  = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1;
    localparam int MASK_W = SEL_W + 1;

    typedef struct packed {
        logic pipe;
    } out_state_t;

    logic [MASK_W-1:0]     mask;
    logic                  single_en;
    logic [SEL_W-1:0]      index;
    logic [NUM_CHAINS-1:0] enable;
    logic                  folded;
    logic                  direct;
    obs_mode_e             mode;
    out_state_t            st_d, st_q;

    scan_mask_reg #(.MASK_W(MASK_W)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .load     (mask_load),
        .ser_in   (mask_in),
        .mask_o   (mask)
    );

    assign single_en = mask[MASK_W-1];
    assign index     = mask[SEL_W-1:0];

    scan_chain_decoder #(.NUM_CHAINS(NUM_CHAINS), .SEL_W(SEL_W)) u_dec (
        .single_en (single_en),
        .index     (index),
        .enable    (enable)
    );

    scan_xor_compactor #(.NUM_CHAINS(NUM_CHAINS)) u_xor (
        .chain_in (chain_in),
        .enable   (enable),
        .folded   (folded)
    );

    always_comb begin
        direct = 1'b0;
        for (int k = 0; k < NUM_CHAINS; k++) begin
            if (index == SEL_W'(k)) direct = chain_in[k];
        end
    end

    always_comb begin
        mode = pick_mode(bypass_en, single_en);
        st_d = st_q;
        if (rst) begin
            st_d.pipe = 1'b0;
        end else if (shift_en) begin
            if (mode == OBS_BYPASS) st_d.pipe = direct;
            else                    st_d.pipe = folded;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign scan_out = st_q.pipe;

    // R2/R1: with the enable clear every chain is passed to the tree
    a_r2_all_observed: assert property (@(posedge clk) disable iff (rst)
        !single_en |-> (&enable));

    // R3: exactly one chain open in single-chain mode
    a_r3_single_open: assert property (@(posedge clk) disable iff (rst)
        single_en |-> ($countones(enable) == 1));

    // R4: bypass delivers the indexed chain after one edge
    a_r4_bypass_path: assert property (@(posedge clk) disable iff (rst)
        (shift_en && bypass_en) |=> (scan_out == $past(chain_in[index])));

    // R7: channel holds while not shifting
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(scan_out));

    // R8: reset clears the channel register
    a_r8_out_reset: assert property (@(posedge clk)
        rst |=> !scan_out);
endmodule

// File: tb/scan_compactor_top_test.sv
module scan_compactor_top_test;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         shift_en;
    logic [N-1:0] chain_in;
    logic         bypass_en;
    logic         mask_load;
    logic         mask_in;
    logic         scan_out;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    scan_compactor_top #(.NUM_CHAINS(N)) uut (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .chain_in  (chain_in),
        .bypass_en (bypass_en),
        .mask_load (mask_load),
        .mask_in   (mask_in),
        .scan_out  (scan_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: scan_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // R5: bits go in index bit 0 first, single-chain enable last
    task automatic load_mask(input logic en, input logic [1:0] idx);
        logic [2:0] bits;
        bits = {en, idx};
        shift_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            mask_load = 1'b1;
            mask_in   = bits[i];
            step();
        end
        mask_load = 1'b0;
        mask_in   = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; shift_en = 1'b1; chain_in = 4'b1011;
        bypass_en = 1'b0; mask_load = 1'b0; mask_in = 1'b0;
        step();
        check("R8 reset clears output", scan_out, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        shift_en = 1'b1;
        chain_in = 4'b0111;
        step();
        check("R2 all chains observed after reset", scan_out, 1'b1);
        chain_in = 4'b1001;
        step();
        check("R2 all chains observed after reset", scan_out, 1'b0);
    endtask

    task automatic t_compacted();
        shift_en = 1'b1; bypass_en = 1'b0;
        for (int p = 0; p < 16; p++) begin
            chain_in = 4'(p);
            step();
            check("R1 xor of all chains, one cycle", scan_out, ^4'(p));
        end
    endtask

    task automatic t_single();
        bypass_en = 1'b0;
        for (int s = 0; s < N; s++) begin
            load_mask(1'b1, 2'(s));
            shift_en = 1'b1;
            for (int p = 0; p < 16; p++) begin
                chain_in = 4'(p);
                step();
                check("R3 selected chain only", scan_out, chain_in[s]);
            end
        end
        load_mask(1'b0, 2'd0);
        shift_en = 1'b1;
        chain_in = 4'b1101;
        step();
        check("R5 enable cleared restores xor", scan_out, 1'b1);
    endtask

    task automatic t_bypass();
        load_mask(1'b0, 2'd2);
        shift_en = 1'b1; bypass_en = 1'b1;
        for (int p = 0; p < 16; p++) begin
            chain_in = 4'(p);
            step();
            check("R4 bypass index 2 enable clear", scan_out, chain_in[2]);
        end
        load_mask(1'b1, 2'd1);
        shift_en = 1'b1; bypass_en = 1'b1;
        for (int p = 0; p < 16; p++) begin
            chain_in = 4'(p);
            step();
            check("R4 bypass index 1 enable set", scan_out, chain_in[1]);
        end
        bypass_en = 1'b0;
    endtask

    task automatic t_load_ignored();
        do_reset();
        shift_en = 1'b1; mask_load = 1'b1; mask_in = 1'b1;
        chain_in = 4'b0000;
        for (int i = 0; i < 3; i++) step();
        mask_load = 1'b0; mask_in = 1'b0;
        chain_in = 4'b0111;
        step();
        check("R6 mask load ignored during shift", scan_out, 1'b1);
    endtask

    task automatic t_hold();
        shift_en = 1'b1; bypass_en = 1'b0;
        chain_in = 4'b0001;
        step();
        check("R7 captured before hold", scan_out, 1'b1);
        shift_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chain_in = 4'(i * 3);
            step();
            check("R7 hold while shift_en low", scan_out, 1'b1);
        end
    endtask

    task automatic t_reset_mid();
        load_mask(1'b1, 2'd3);
        shift_en = 1'b1;
        chain_in = 4'b1000;
        step();
        check("R3 before mid reset", scan_out, 1'b1);
        do_reset();
        shift_en = 1'b1;
        chain_in = 4'b0011;
        step();
        check("R8 mask cleared by reset", scan_out, 1'b0);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        rst = 1'b1; shift_en = 1'b0; chain_in = '0;
        bypass_en = 1'b0; mask_load = 1'b0; mask_in = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_compacted();
        t_single();
        t_bypass();
        t_load_ignored();
        t_hold();
        t_reset_mid();
        finish_run();
    end
endmodule